// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is a slave on a two-wire serial bus (SMBus/I2C style) that gives a host access to a small internal register file through an address pointer. SCL and SDA are synchronised to the system clock and oversampled. Start and stop conditions are detected from SDA edges that occur while SCL is high. The slave drives SDA only through an open-drain output enable: when the enable is high, the pin is pulled low.

A write transfer has the device address byte, then a pointer byte, then an optional data byte. The data byte is stored into the register the pointer selects. A read transfer returns exactly one byte, taken from the register the pointer currently selects. The pointer does not advance after an access and is kept from one transfer to the next. A repeated start lets a host load the pointer and then read from it within one bus operation.

Top module: `smb_ptr_slave`

## Requirements
- R1: An SDA fall while SCL is high is a start and an SDA rise while SCL is high is a stop. Either one releases SDA. A start, including a repeated start, returns the slave to receiving an address byte, and the pointer loaded before a repeated start is used by the read that follows it.
- R2: `sda_oe_o` changes only while SCL is low.
- R3: Bytes are shifted MSB first, one bit sampled on each rising SCL edge, and a ninth clock follows each byte. The address byte matches when its upper seven bits equal `{DEV_BASE, addr_sel_i}`, with `addr_sel_i` forming the two lowest address bits. Bit 0 of the address byte selects the direction: 0 for write, 1 for read. On a match, the slave acknowledges by holding `sda_oe_o` high during the ninth clock.
- R4: On an address mismatch, the slave does not acknowledge. It then ignores every following byte until the next start, and no register is written.
- R5: The first byte after a write address is acknowledged and loaded into the pointer. The pointer keeps its value across stop conditions and later transfers.
- R6: The second byte of a write is acknowledged and stored into the selected register. For one cycle `wr_stb_o` pulses, with `reg_sel_o` equal to the pointer and `wr_data_o` equal to the byte.
- R7: A third or later byte of a write is not acknowledged and changes no register.
- R8: A read drives the selected register value MSB first and pulses `rd_stb_o` once. The pointer does not auto-increment, so repeated reads return the same register.
- R9: On the ninth clock of a read byte, the slave leaves SDA released so the host can signal no-acknowledge and then a stop.
- R10: When the pointer is at or above `NUM_REGS`, a data byte is still acknowledged but discarded, and a read returns 0x00.
- R11: After reset, SDA is released, the pointer is 0 and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 2 | Strap bits forming the two lowest address bits |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| wr_stb_o | output | 1 | One-cycle register write pulse |
| rd_stb_o | output | 1 | One-cycle register read pulse |
| reg_sel_o | output | 8 | Current pointer value |
| wr_data_o | output | 8 | Data byte of the latest write |

## Verification
The hardest case to reach from the ports is a third write byte arriving after a register was written successfully. Here the slave must stop acknowledging while the stored value stays intact. The bench builds this case explicitly and then reads the register back in a fresh transfer. The bench also uses a repeated start inside one operation, so a pointer loaded in the write phase feeds the read phase without a stop in between. Pointer values past the register count are reached by sweeping every pointer up to 15 against a 12-entry file.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_IGNORE
  } st_e;

  typedef enum logic [1:0] {
    BY_ADDR, BY_PTR, BY_DATA, BY_EXTRA
  } byte_e;
endpackage

// File: rtl/smb_ptr_sync.sv
module smb_ptr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // idle bus is high
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/smb_ptr_cond.sv
module smb_ptr_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s_i;
      sda_d <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_d;
  assign scl_fall_o = ~scl_s_i & scl_d;
  assign start_o    = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_d & ~sda_d & sda_s_i;

  AST_NO_START_STOP_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));  // R1
endmodule

// File: rtl/smb_ptr_regs.sv
module smb_ptr_regs #(
  parameter int NUM_REGS = 12,
  parameter int PTR_W    = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] mem_q [NUM_REGS];
  logic              in_range;

  assign in_range = ({1'b0, addr_i} < (PTR_W+1)'(NUM_REGS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[i] <= '0;
      else if (we_i && addr_i == PTR_W'(i))          mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_range) rdata_o = mem_q[addr_i[IDX_W-1:0]];
  end
endmodule

// File: rtl/smb_ptr_fsm.sv
module smb_ptr_fsm
  import smb_ptr_pkg::*;
#(
  parameter logic [4:0] DEV_BASE = 5'b01011,
  parameter int         PTR_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       addr_sel_i,
  input  logic [7:0]       rdata_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_stb_o,
  output logic [7:0]       wr_data_o,
  output logic             rd_stb_o
);
  st_e             st_q;
  byte_e           kind_q;
  logic [2:0]      bitcnt_q;
  logic            full_q;
  logic [7:0]      sh_q;
  logic            rd_mode_q;
  logic            oe_q;
  logic [PTR_W-1:0] ptr_q;
  logic            wr_stb_q, rd_stb_q;
  logic [7:0]      wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= BY_ADDR;
      bitcnt_q  <= '0;
      full_q    <= 1'b0;
      sh_q      <= '0;
      rd_mode_q <= 1'b0;
      oe_q      <= 1'b0;
      ptr_q     <= '0;
      wr_stb_q  <= 1'b0;
      rd_stb_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_stb_q <= 1'b0;
      rd_stb_q <= 1'b0;
      if (start_i) begin
        st_q     <= ST_RX;
        kind_q   <= BY_ADDR;
        bitcnt_q <= '0;
        full_q   <= 1'b0;
        oe_q     <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q     <= {sh_q[6:0], sda_s_i};
              bitcnt_q <= bitcnt_q + 3'd1;
              if (bitcnt_q == 3'd7) full_q <= 1'b1;
            end else if (scl_fall_i && full_q) begin
              full_q <= 1'b0;
              unique case (kind_q)
                BY_ADDR: begin
                  if (sh_q[7:1] == {DEV_BASE, addr_sel_i}) begin
                    oe_q      <= 1'b1;
                    rd_mode_q <= sh_q[0];
                    kind_q    <= BY_PTR;
                    st_q      <= ST_ACK;
                  end else begin
                    st_q <= ST_IGNORE;
                  end
                end
                BY_PTR: begin
                  ptr_q  <= sh_q[PTR_W-1:0];
                  oe_q   <= 1'b1;
                  kind_q <= BY_DATA;
                  st_q   <= ST_ACK;
                end
                BY_DATA: begin
                  wr_stb_q  <= 1'b1;
                  wr_data_q <= sh_q;
                  oe_q      <= 1'b1;
                  kind_q    <= BY_EXTRA;
                  st_q      <= ST_ACK;
                end
                default: st_q <= ST_IGNORE;  // surplus byte: no ack
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bitcnt_q <= '0;
              if (rd_mode_q) begin
                sh_q     <= rdata_i;
                rd_stb_q <= 1'b1;
                oe_q     <= ~rdata_i[7];
                st_q     <= ST_TX;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bitcnt_q == 3'd7) begin
                oe_q <= 1'b0;
                st_q <= ST_MACK;
              end else begin
                oe_q     <= ~sh_q[6];
                sh_q     <= {sh_q[6:0], 1'b0};
                bitcnt_q <= bitcnt_q + 3'd1;
              end
            end
          end
          ST_MACK: if (scl_rise_i) st_q <= ST_IGNORE;  // one byte per read
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_stb_o  = wr_stb_q;
  assign wr_data_o = wr_data_q;
  assign rd_stb_o  = rd_stb_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !scl_s_i);  // R2
  AST_START_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !oe_q);  // R1
  AST_WRITE_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_q |-> oe_q);  // R6
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_q && rd_stb_q));  // R8
  AST_IGNORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGNORE && $past(st_q) == ST_IGNORE) |-> (!oe_q && !wr_stb_q));  // R4
  AST_MACK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MACK) |-> !oe_q);  // R9
endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave #(
  parameter logic [4:0] DEV_BASE    = 5'b01011,
  parameter int         NUM_REGS    = 12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel_i,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic       rd_stb_o,
  output logic [7:0] reg_sel_o,
  output logic [7:0] wr_data_o
);
  localparam int PTR_W = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [7:0] rdata;

  smb_ptr_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  smb_ptr_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  smb_ptr_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop));

  smb_ptr_fsm #(.DEV_BASE(DEV_BASE), .PTR_W(PTR_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .addr_sel_i(addr_sel_i), .rdata_i(rdata), .sda_oe_o(sda_oe_o),
    .ptr_o(reg_sel_o), .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
    .rd_stb_o(rd_stb_o));

  smb_ptr_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .DATA_W(8)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_stb_o), .addr_i(reg_sel_o),
    .wdata_i(wr_data_o), .rdata_o(rdata));
endmodule

// File: tb/smb_ptr_slave_bench.sv
module smb_ptr_slave_bench;
  localparam int NREG = 12;
  localparam int Q    = 5;
  localparam logic [6:0] DEV = 7'h2E;  // {01011, 10}

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb, rd_stb;
  logic [7:0] reg_sel, wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_sel = '0, last_data = '0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  smb_ptr_slave #(.NUM_REGS(NREG)) u_smb_ptr_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(2'b10), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb),
    .reg_sel_o(reg_sel), .wr_data_o(wr_data));

  always @(negedge clk) begin
    if (wr_stb) begin wr_cnt++; last_sel = reg_sel; last_data = wr_data; end
    if (rd_stb) rd_cnt++;
    if (rst_n && sda_oe != prev_oe) begin
      checks++;
      if (scl_m) begin errors++; $display("FAIL R2 oe changed with SCL high act=%0b exp=%0b", sda_oe, prev_oe); end
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; waitq(1);
    scl_m = 1'b1; waitq(1);
    sda_m = 1'b0; waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; waitq(1);
    scl_m = 1'b1; waitq(1);
    sda_m = 1'b1; waitq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq(1);
      scl_m = 1'b1; waitq(2);
      scl_m = 1'b0; waitq(1);
    end
    sda_m = 1'b1; waitq(1);
    scl_m = 1'b1; waitq(1);
    ack = !sda_bus;
    waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  task automatic read_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(1);
      scl_m = 1'b1; waitq(1);
      b[i] = sda_bus;
      waitq(1);
      scl_m = 1'b0;
    end
    waitq(1);
    scl_m = 1'b1; waitq(1);
    chk(sda_oe == 1'b0, "R9 released on ninth read clock", sda_oe, 0);
    waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  task automatic do_read(output logic [7:0] b, output bit ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    read_byte(b);
    bus_stop();
  endtask

  task automatic do_write(input logic [7:0] p, input logic [7:0] d, output bit a1, output bit a2);
    bit a0;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte(p, a1);
    send_byte(d, a2);
    bus_stop();
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    summary();
  end

  initial begin
    logic [7:0] rb, exp_v;
    bit ak, a1, a2;
    int wc;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 oe after reset", sda_oe, 0);
    chk(reg_sel == 8'd0, "R11 pointer after reset", reg_sel, 0);
    rst_n = 1'b1;
    waitq(2);
    do_read(rb, ak);
    chk(ak, "R3 read address ack", ak, 1);
    chk(rb == 8'h00, "R11 reg0 reads zero", rb, 0);

    // address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, ak);
      bus_stop();
      chk(ak == (a == int'(DEV)), "R3 address match", ak, a == int'(DEV));
    end
    chk(wr_cnt == 0, "R4 no write after address sweep", wr_cnt, 0);

    // mismatched address followed by data
    bus_start();
    send_byte({7'h2F, 1'b0}, ak);
    send_byte(8'd3, a1);
    send_byte(8'hAA, a2);
    bus_stop();
    chk(!ak && !a1 && !a2, "R4 mismatch ignored", {ak, a1, a2}, 0);
    chk(wr_cnt == 0 && reg_sel == 8'd0, "R4 no write and pointer kept", reg_sel, 0);

    // write/read sweep over pointers incl. out of range
    for (int p = 0; p < 16; p++) begin
      exp_v = 8'(p * 29 + 7);
      wc = wr_cnt;
      do_write(8'(p), exp_v, a1, a2);
      chk(a1, "R5 pointer byte ack", a1, 1);
      chk(a2, "R6 data byte ack (R10 also out of range)", a2, 1);
      chk(wr_cnt == wc + 1 && last_sel == 8'(p) && last_data == exp_v,
          "R6 write strobe sel/data", {last_sel, last_data}, {8'(p), exp_v});
      do_read(rb, ak);
      if (p >= NREG) exp_v = 8'h00;
      chk(rb == exp_v, (p >= NREG) ? "R10 out-of-range read" : "R8 read back", rb, exp_v);
      do_read(rb, ak);
      chk(rb == exp_v, "R8 no auto-increment on second read", rb, exp_v);
      chk(reg_sel == 8'(p), "R5 pointer kept across transfers", reg_sel, p);
    end
    chk(rd_cnt == 33, "R8 one read strobe per read", rd_cnt, 33);

    // repeated start: load pointer then read without stop
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'd5, a1);
    bus_start();
    send_byte({DEV, 1'b1}, a2);
    read_byte(rb);
    bus_stop();
    chk(a1 && a2, "R1 acks around repeated start", {a1, a2}, 3);
    chk(rb == 8'(5 * 29 + 7), "R1 read after repeated start", rb, 5 * 29 + 7);

    // surplus third byte
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'd2, a1);
    send_byte(8'h5A, a2);
    send_byte(8'hC3, ak);
    bus_stop();
    chk(!ak, "R7 third byte not acked", ak, 0);
    do_read(rb, ak);
    chk(rb == 8'h5A, "R7 register unchanged by third byte", rb, 8'h5A);

    // pointer-only write
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'd7, a1);
    bus_stop();
    do_read(rb, ak);
    chk(rb == 8'(7 * 29 + 7), "R5 pointer-only write selects reg", rb, 7 * 29 + 7);

    summary();
  end
endmodule